// File: doc/BRIEF.md
# Selectable power-of-two clock divider

The block takes an incoming clock and produces a slower clock on its output at one of four ratios: the input itself, or the input divided by 2, 4 or 8. A two-bit select picks the ratio. Inside, a three-stage binary counter advances on every falling edge of the input clock, and a tap selector forwards either the raw clock (bypass) or one counter stage. The select is read live, so a change reaches the output at once and the counter keeps running.

An asynchronous active-low reset stops the block. While it is held low, the internal clock is gated off, the counter is cleared, and the output enable drops so that the output can be held in high impedance by the three-state buffer around the block. The release of reset is synchronised to the falling edge of the input clock before the counter may count. The data output and the enable leave the block as separate signals. The high-impedance pad is formed outside it.

Top module: `pow2_clk_div`

## Requirements
- R1: The select `sel_i` (bit 1 is the most significant) chooses the output: 0 is the input clock passed through, 1 is counter stage 0 (divide by 2), 2 is stage 1 (divide by 4), 3 is stage 2 (divide by 8).
- R2: Once running, the counter increases by one modulo 8 on every falling edge of `clk_i`, so a divided output changes only at falling input edges.
- R3: With a fixed select and reset released, the time between two rising edges of the output is 1, 2, 4 or 8 input periods for select 0, 1, 2 and 3.
- R4: While `rst_n_i` is low, `oe_o` is 0, `div_o` is 0 and the counter is cleared at once, without waiting for a clock edge. The external pad is then high impedance.
- R5: After `rst_n_i` rises, the counter holds 0 through the first two falling edges of `clk_i` and reaches 1 on the third. Every divided output therefore starts low.
- R6: While reset is held, the internal clock is gated off: in bypass mode `div_o` stays 0 even though `clk_i` toggles. After release, the output follows `clk_i` from its next high phase.
- R7: A change of `sel_i` changes `div_o` to the newly selected path within the same clock phase and does not reset or disturb the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided; the counter acts on its falling edge |
| rst_n_i | input | 1 | Asynchronous active-low reset and clock stop |
| sel_i | input | 2 | Division select, see R1 |
| div_o | output | 1 | Divided clock data, 0 while in reset |
| oe_o | output | 1 | Enable for the external three-state buffer, 1 when running |

## Verification
The hardest situation to bring about is a select change or a reset edge that lands mid-count. The counter phase then decides what the output must show, and that phase is visible only through the divided taps. The stimulus asserts reset with the counter at an arbitrary value and releases it while the clock is high. It then moves the select on falling-edge half cycles through a scrambled sequence, so that every tap is observed at many counter phases. A behavioural model of the count, including the two-edge release delay, predicts the pad value in both clock phases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DEF_STAGES    = 3;
  localparam int unsigned DEF_SYNC_LEN  = 2;

  function automatic int unsigned sel_width(input int unsigned stages);
    return (stages + 1 <= 2) ? 1 : $clog2(stages + 1);
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned LEN = clkdiv_pkg::DEF_SYNC_LEN
) (
  input  logic clk_fall_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [LEN-1:0] sync_q;
  logic [LEN-1:0] sync_d;

  always_comb begin
    sync_d = (sync_q << 1) | LEN'(1);
  end

  always_ff @(negedge clk_fall_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign srst_n_o = sync_q[LEN-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned STAGES = clkdiv_pkg::DEF_STAGES
) (
  input  logic              clk_fall_i,
  input  logic              arst_n_i,
  input  logic              en_i,
  output logic [STAGES-1:0] count_o
);
  logic [STAGES-1:0] count_q;
  logic [STAGES-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (en_i) count_d = count_q + STAGES'(1);
  end

  always_ff @(negedge clk_fall_i or negedge arst_n_i) begin
    if (!arst_n_i) count_q <= '0;
    else           count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/clkdiv_tap_sel.sv
module clkdiv_tap_sel #(
  parameter int unsigned STAGES = clkdiv_pkg::DEF_STAGES,
  parameter int unsigned SEL_W  = clkdiv_pkg::sel_width(STAGES)
) (
  input  logic              clk_pass_i,
  input  logic [STAGES-1:0] count_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              oe_i,
  output logic              div_o
);
  localparam int unsigned TAPS = STAGES + 1;

  logic [TAPS-1:0] taps;
  logic [TAPS-1:0] hit;

  assign taps = {count_i, clk_pass_i};

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign hit[t] = (sel_i == SEL_W'(t)) & taps[t];
  end

  assign div_o = oe_i & (|hit);
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div #(
  parameter int unsigned STAGES   = clkdiv_pkg::DEF_STAGES,
  parameter int unsigned SYNC_LEN = clkdiv_pkg::DEF_SYNC_LEN,
  parameter int unsigned SEL_W    = clkdiv_pkg::sel_width(STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_o,
  output logic             oe_o
);
  logic              clk_run;
  logic              rst_sync_n;
  logic [STAGES-1:0] count_q;

  // clock stop: the source is gated while reset is held
  assign clk_run = clk_i & rst_n_i;
  assign oe_o    = rst_n_i;

  clkdiv_rst_sync #(.LEN(SYNC_LEN)) u_rst_sync (
    .clk_fall_i (clk_run),
    .arst_n_i   (rst_n_i),
    .srst_n_o   (rst_sync_n)
  );

  clkdiv_counter #(.STAGES(STAGES)) u_counter (
    .clk_fall_i (clk_run),
    .arst_n_i   (rst_n_i),
    .en_i       (rst_sync_n),
    .count_o    (count_q)
  );

  clkdiv_tap_sel #(.STAGES(STAGES), .SEL_W(SEL_W)) u_tap_sel (
    .clk_pass_i (clk_run),
    .count_i    (count_q),
    .sel_i      (sel_i),
    .oe_i       (oe_o),
    .div_o      (div_o)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int unsigned STAGES = clkdiv_pkg::DEF_STAGES,
  parameter int unsigned SEL_W  = clkdiv_pkg::sel_width(STAGES)
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              rst_sync_n,
  input logic [SEL_W-1:0]  sel_i,
  input logic [STAGES-1:0] count_q,
  input logic              div_o,
  input logic              oe_o
);
  // R4: reset holds the outputs quiet and the counter cleared
  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      assert_quiet_in_reset_R4: assert (!oe_o && !div_o && count_q == '0)
        else $error("reset state violated");
    end
  end

  // R2: one step per falling edge once running
  assert_count_step_R2: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    rst_sync_n |=> count_q == $past(count_q) + STAGES'(1));

  // R5: counter held at zero until the release is synchronised
  assert_hold_until_sync_R5: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    !rst_sync_n |-> count_q == '0);

  // R1: a divide select shows the matching counter stage
  assert_stage_tap_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_i != '0 && sel_i <= SEL_W'(STAGES)) |-> div_o == count_q[sel_i - SEL_W'(1)]);

  // R1: bypass output is high just before each falling edge
  assert_bypass_high_R1: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (sel_i == '0 && $past(rst_n_i)) |-> div_o);
endmodule

bind pow2_clk_div clkdiv_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .rst_sync_n (rst_sync_n),
  .sel_i      (sel_i),
  .count_q    (count_q),
  .div_o      (div_o),
  .oe_o       (oe_o)
);

// File: tb/pow2_clk_div_tb.sv
`timescale 1ns/1ps
module pow2_clk_div_tb;
  logic       clk;
  logic       rst_n;
  logic [1:0] sel;
  logic       div;
  logic       oe;
  wire        pad;

  int vectors = 0;
  int errors  = 0;
  bit chk_en  = 0;
  bit done    = 0;
  string tag  = "R4";

  // reference state
  int m_cnt  = 0;
  int m_sync = 0;

  pow2_clk_div u_dut (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .sel_i   (sel),
    .div_o   (div),
    .oe_o    (oe)
  );

  assign pad = oe ? div : 1'bz;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_sync >= 2) m_cnt = (m_cnt + 1) % 8;
      else             m_sync++;
    end
  end

  task automatic compare();
    logic exp_pad;
    logic exp_oe;
    if (!rst_n) begin
      m_cnt = 0; m_sync = 0;
      exp_pad = 1'bz; exp_oe = 1'b0;
    end else begin
      exp_oe = 1'b1;
      if (sel == 2'd0) exp_pad = clk;
      else             exp_pad = 1'((m_cnt >> (sel - 1)) & 1);
    end
    vectors++;
    if (pad !== exp_pad || oe !== exp_oe) begin
      errors++;
      $display("FAIL %s t=%0t sel=%0d pad=%b oe=%b expected pad=%b oe=%b",
               tag, $time, sel, pad, oe, exp_pad, exp_oe);
    end
  endtask

  always @(posedge clk) if (chk_en) begin #1.25; compare(); end
  always @(negedge clk) if (chk_en) begin #1.25; compare(); end

  task automatic at_high();  @(posedge clk); #0.5; endtask
  task automatic at_low();   @(negedge clk); #0.5; endtask

  task automatic measure(input logic [1:0] s);
    realtime t0, t1, want;
    @(posedge pad); t0 = $realtime;
    @(posedge pad); t1 = $realtime;
    want = 5.0 * (1 << s);
    vectors++;
    if (t1 - t0 != want) begin
      errors++;
      $display("FAIL R3 sel=%0d period=%0.2f expected %0.2f", s, t1 - t0, want);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    sel   = 2'd3;
    chk_en = 1;
    // R4: reset state, pad high impedance
    tag = "R4";
    repeat (3) at_high();
    // R5: synchronised release, divided output starts low
    tag = "R5";
    rst_n = 1'b1;
    repeat (12) at_high();
    // R2/R3: every select held, period measured
    for (int s = 0; s < 4; s++) begin
      at_low();
      tag = "R7";
      sel = 2'(s);
      repeat (4) at_high();
      tag = "R2";
      measure(2'(s));
      tag = "R3";
      repeat (3) at_high();
    end
    // R4: reset mid-count, counter cleared at once
    repeat (3) at_high();
    tag = "R4";
    rst_n = 1'b0;
    repeat (2) at_high();
    // R6: bypass stays low while the clock is gated
    tag = "R6";
    sel = 2'd0;
    repeat (4) at_high();
    rst_n = 1'b1;
    repeat (3) at_high();
    measure(2'd0);
    // R7: scrambled live select changes
    tag = "R7";
    for (int i = 0; i < 40; i++) begin
      at_low();
      sel = 2'((i * 7 + i / 3) % 4);
    end
    // R1: each encoding once more after the scramble
    tag = "R1";
    for (int s = 3; s >= 0; s--) begin
      at_low();
      sel = 2'(s);
      repeat (9) at_high();
    end
    // R5: second reset release in divide-by-2
    tag = "R5";
    sel = 2'd1;
    rst_n = 1'b0;
    repeat (2) at_high();
    rst_n = 1'b1;
    repeat (8) at_high();
    chk_en = 0;
    #5;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule